// File: doc/BRIEF.md
# Single-Bus Operand-Latched ALU

This block is the arithmetic and logic stage of a 32-bit datapath built around one shared bus. Because only one value can be on the bus in a cycle, one operand of every binary operation is kept in a holding register (the operand latch, Y). Y is loaded from the bus in an earlier cycle. The other operand is whatever is on the bus in the current cycle. The function unit evaluates continuously. A result register (Z) takes a snapshot of its output only in cycles where the controller asks for it.

The controller selects the operation with a one-hot select vector. It loads Y and Z with two load strobes and lets either register drive the bus with two drive enables. A flag reports whether Z currently holds zero, which a conditional branch step can test. Operand order is not symmetric. Subtract and set-less-than take Y as the left operand. Both shifts shift the bus value by an amount taken from Y.

Top module: `sbus_alu`

## Requirements
- R1: The select vector `op_sel` is one-hot: bit 0 = add, bit 1 = AND, bit 2 = XOR, bit 3 = OR, bit 4 = shift left, bit 5 = set-less-than, bit 6 = shift right, bit 7 = subtract. Add gives Y + bus, and AND/XOR/OR give the bitwise result of Y and bus, all modulo 2^32.
- R2: Subtract gives Y − bus, modulo 2^32.
- R3: Set-less-than compares Y and bus as signed two's-complement numbers. It gives 32'd1 when Y < bus and 32'd0 otherwise.
- R4: Shift left gives bus << Y[4:0], and shift right gives bus >> Y[4:0], both with zero fill. Bits of Y above bit 4 have no effect.
- R5: When `y_load` is high at a rising edge, Y takes the bus value. Otherwise Y holds its value.
- R6: When `z_load` is high at a rising edge, Z takes the function result for the current bus, Y and select. Otherwise Z holds its value.
- R7: `y_bus_out` equals Y while `y_drive` is high and is zero otherwise. `z_bus_out` equals Z while `z_drive` is high and is zero otherwise.
- R8: When more than one select bit is high, `op_err` is high and the result is zero. When no select bit is high, the result is zero and `op_err` is low.
- R9: `z_zero` is high exactly when Z holds zero.
- R10: While `rst_n` is low, Y and Z are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 8 | One-hot operation select |
| y_load | input | 1 | Capture bus into Y at the edge |
| z_load | input | 1 | Capture function result into Z at the edge |
| y_drive | input | 1 | Put Y on the bus drive output |
| z_drive | input | 1 | Put Z on the bus drive output |
| bus_in | input | 32 | Current shared bus value |
| y_bus_out | output | 32 | Y drive value, zero when not enabled |
| z_bus_out | output | 32 | Z drive value, zero when not enabled |
| z_zero | output | 1 | Z holds zero |
| op_err | output | 1 | More than one select bit high |

## Verification
Every operation is tried on the full cross product of a set of operand values. The set covers zero, one, all-ones, the most negative value, the most positive value, a mixed pattern and shift amounts of 5, 31, 32 and 33. Running each value in both operand positions separates Y − bus from bus − Y, and it separates signed from unsigned comparison through the sign-boundary values. Shift amounts of 32 and 33 show that only the low five bits of Y count. Separate sequences preload Z with a nonzero value and then apply no load, a multiple select or an empty select, which shows hold, error zeroing and the zero flag at the drive outputs.

// File: rtl/sbus_alu_pkg.sv
`timescale 1ns/1ps
package sbus_alu_pkg;
    localparam int OP_N = 8;
    localparam int OP_IDX_W = $clog2(OP_N);

    typedef enum logic [OP_IDX_W-1:0] {
        OP_ADD = 3'd0,
        OP_AND = 3'd1,
        OP_XOR = 3'd2,
        OP_OR  = 3'd3,
        OP_SLL = 3'd4,
        OP_SLT = 3'd5,
        OP_SRL = 3'd6,
        OP_SUB = 3'd7
    } alu_op_e;
endpackage

// File: rtl/sbus_alu_opdec.sv
`timescale 1ns/1ps
module sbus_alu_opdec
    import sbus_alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_N-1:0] sel_i,
    output alu_op_e         op_o,
    output logic            valid_o,
    output logic            err_o
);
    localparam int CNT_W = $clog2(OP_N + 1);

    logic [CNT_W-1:0] hits;
    logic [OP_IDX_W-1:0] idx;

    always_comb begin
        hits = '0;
        idx  = '0;
        for (int i = 0; i < OP_N; i++) begin
            if (sel_i[i]) begin
                hits = hits + CNT_W'(1);
                idx  = OP_IDX_W'(i);
            end
        end
    end

    assign op_o    = alu_op_e'(idx);
    assign valid_o = (hits == CNT_W'(1));
    assign err_o   = (hits > CNT_W'(1));

    // R8: a multi-bit select must always raise the error
    p_multi_sel_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(sel_i) > 1) |-> (err_o && !valid_o));

    // R8: an empty select is neither valid nor an error
    p_empty_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == '0) |-> (!err_o && !valid_o));
endmodule

// File: rtl/sbus_alu_core.sv
`timescale 1ns/1ps
module sbus_alu_core
    import sbus_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  alu_op_e           op_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] left_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] result_o
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0] shamt;
    logic            lt_signed;

    assign shamt     = left_i[SH_W-1:0];
    assign lt_signed = ($signed(left_i) < $signed(bus_i));

    always_comb begin
        result_o = '0;
        if (valid_i) begin
            unique case (op_i)
                OP_ADD: result_o = left_i + bus_i;
                OP_AND: result_o = left_i & bus_i;
                OP_XOR: result_o = left_i ^ bus_i;
                OP_OR:  result_o = left_i | bus_i;
                OP_SLL: result_o = bus_i << shamt;
                OP_SLT: result_o = {{(DATA_W-1){1'b0}}, lt_signed};
                OP_SRL: result_o = bus_i >> shamt;
                OP_SUB: result_o = left_i - bus_i;
                default: result_o = '0;
            endcase
        end
    end

    // R3: comparison result is a clean boolean word
    p_slt_bool_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_SLT) |-> (result_o[DATA_W-1:1] == '0));

    // R2: subtract and add are inverse with respect to the bus operand
    p_sub_inverse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_SUB) |-> ((result_o + bus_i) == left_i));
endmodule

// File: rtl/sbus_alu_regs.sv
`timescale 1ns/1ps
module sbus_alu_regs #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              y_load_i,
    input  logic              z_load_i,
    input  logic [DATA_W-1:0] bus_i,
    input  logic [DATA_W-1:0] result_i,
    output logic [DATA_W-1:0] y_o,
    output logic [DATA_W-1:0] z_o
);
    typedef struct packed {
        logic [DATA_W-1:0] y;
        logic [DATA_W-1:0] z;
    } regs_t;

    regs_t regs_d;
    regs_t regs_q;

    always_comb begin
        regs_d = regs_q;
        if (y_load_i) begin
            regs_d.y = bus_i;
        end
        if (z_load_i) begin
            regs_d.z = result_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign y_o = regs_q.y;
    assign z_o = regs_q.z;

    // R5: Y follows the bus on a load strobe
    p_y_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        y_load_i |=> (regs_q.y == $past(bus_i)));

    // R5: Y is held without a load strobe
    p_y_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !y_load_i |=> $stable(regs_q.y));

    // R6: Z is held without a load strobe
    p_z_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !z_load_i |=> $stable(regs_q.z));

    // R6: Z takes the function result on a load strobe
    p_z_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        z_load_i |=> (regs_q.z == $past(result_i)));
endmodule

// File: rtl/sbus_alu.sv
`timescale 1ns/1ps
module sbus_alu
    import sbus_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        op_sel,
    input  logic              y_load,
    input  logic              z_load,
    input  logic              y_drive,
    input  logic              z_drive,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] y_bus_out,
    output logic [DATA_W-1:0] z_bus_out,
    output logic              z_zero,
    output logic              op_err
);
    alu_op_e           op;
    logic              op_valid;
    logic [DATA_W-1:0] alu_res;
    logic [DATA_W-1:0] y_val;
    logic [DATA_W-1:0] z_val;

    sbus_alu_opdec u_opdec (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (op_sel),
        .op_o    (op),
        .valid_o (op_valid),
        .err_o   (op_err)
    );

    sbus_alu_core #(.DATA_W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op),
        .valid_i  (op_valid),
        .left_i   (y_val),
        .bus_i    (bus_in),
        .result_o (alu_res)
    );

    sbus_alu_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .y_load_i (y_load),
        .z_load_i (z_load),
        .bus_i    (bus_in),
        .result_i (alu_res),
        .y_o      (y_val),
        .z_o      (z_val)
    );

    assign y_bus_out = y_drive ? y_val : '0;
    assign z_bus_out = z_drive ? z_val : '0;
    assign z_zero    = (z_val == '0);

    // R8: an error select forces a zero result
    p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |-> (alu_res == '0));

    // R9: loading a zero result raises the flag next cycle
    p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (z_load && alu_res == '0) |=> z_zero);

    // R9: loading a nonzero result clears the flag next cycle
    p_nonzero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (z_load && alu_res != '0) |=> !z_zero);
endmodule

// File: tb/sbus_alu_tb_top.sv
`timescale 1ns/1ps
module sbus_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op_sel = '0;
    logic        y_load = 1'b0;
    logic        z_load = 1'b0;
    logic        y_drive = 1'b0;
    logic        z_drive = 1'b0;
    logic [31:0] bus_in = '0;
    logic [31:0] y_bus_out;
    logic [31:0] z_bus_out;
    logic        z_zero;
    logic        op_err;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sbus_alu dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_sel    (op_sel),
        .y_load    (y_load),
        .z_load    (z_load),
        .y_drive   (y_drive),
        .z_drive   (z_drive),
        .bus_in    (bus_in),
        .y_bus_out (y_bus_out),
        .z_bus_out (z_bus_out),
        .z_zero    (z_zero),
        .op_err    (op_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input int k, input logic [31:0] y, input logic [31:0] b);
        case (k)
            0: return y + b;
            1: return y & b;
            2: return y ^ b;
            3: return y | b;
            4: return b << y[4:0];
            5: return ($signed(y) < $signed(b)) ? 32'd1 : 32'd0;
            6: return b >> y[4:0];
            default: return y - b;
        endcase
    endfunction

    function automatic string req_of(input int k);
        case (k)
            4, 6: return "R4";
            5: return "R3";
            7: return "R2";
            default: return "R1";
        endcase
    endfunction

    // load Y, then compute into Z, then read Z back through its drive output
    task automatic run_op(input logic [31:0] y, input logic [31:0] b, input logic [7:0] sel);
        @(negedge clk);
        bus_in = y; y_load = 1'b1; z_load = 1'b0; op_sel = '0;
        @(negedge clk);
        y_load = 1'b0; bus_in = b; op_sel = sel; z_load = 1'b1;
        @(negedge clk);
        z_load = 1'b0; op_sel = '0; bus_in = '0; z_drive = 1'b1;
        #1;
    endtask

    logic [31:0] vals [10];

    initial begin
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
        vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h8000_0000;
        vals[4] = 32'h7FFF_FFFF; vals[5] = 32'h1234_5678;
        vals[6] = 32'd31;        vals[7] = 32'd32;
        vals[8] = 32'd33;        vals[9] = 32'd5;

        bus_in = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        y_drive = 1'b1; z_drive = 1'b1;
        #1;
        chk("R10 Y reset", y_bus_out, 32'h0);
        chk("R10 Z reset", z_bus_out, 32'h0);
        chk("R9 flag after reset", {31'h0, z_zero}, 32'h1);
        @(negedge clk);
        rst_n = 1'b1;

        // full sweep of ops over operand cross product
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < 10; i++) begin
                for (int j = 0; j < 10; j++) begin
                    logic [31:0] e;
                    e = model(k, vals[i], vals[j]);
                    run_op(vals[i], vals[j], 8'(1 << k));
                    chk(req_of(k), z_bus_out, e);
                    chk("R9 zero flag", {31'h0, z_zero}, {31'h0, (e == 32'h0)});
                    chk("R5 Y captured", y_bus_out, vals[i]);
                end
            end
        end

        // R6 hold: preload Z nonzero, then no load with a changing bus
        run_op(32'h10, 32'h5, 8'h01);
        chk("R6 preload", z_bus_out, 32'h15);
        @(negedge clk);
        bus_in = 32'hFFFF_0000; op_sel = 8'h80; z_load = 1'b0;
        @(negedge clk);
        op_sel = '0; #1;
        chk("R6 Z hold", z_bus_out, 32'h15);
        chk("R5 Y hold", y_bus_out, 32'h10);

        // R7 drive enables off
        y_drive = 1'b0; z_drive = 1'b0; #1;
        chk("R7 Y drive off", y_bus_out, 32'h0);
        chk("R7 Z drive off", z_bus_out, 32'h0);
        y_drive = 1'b1; z_drive = 1'b1;

        // R8 multiple select zeroes result and flags error
        @(negedge clk);
        op_sel = 8'h81; bus_in = 32'h3; #1;
        chk("R8 err multi", {31'h0, op_err}, 32'h1);
        z_load = 1'b1;
        @(negedge clk);
        z_load = 1'b0; op_sel = '0; #1;
        chk("R8 multi zero", z_bus_out, 32'h0);
        chk("R9 flag on zero", {31'h0, z_zero}, 32'h1);
        chk("R8 err clears", {31'h0, op_err}, 32'h0);

        // R8 empty select: zero, no error
        run_op(32'h7, 32'h9, 8'h02);
        chk("R1 preload AND", z_bus_out, 32'h1);
        @(negedge clk);
        op_sel = 8'h00; bus_in = 32'h9; z_load = 1'b1; #1;
        chk("R8 empty no err", {31'h0, op_err}, 32'h0);
        @(negedge clk);
        z_load = 1'b0; #1;
        chk("R8 empty zero", z_bus_out, 32'h0);

        // R10 reset mid-run clears loaded registers
        run_op(32'hABCD, 32'h1, 8'h01);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R10 Y cleared", y_bus_out, 32'h0);
        chk("R10 Z cleared", z_bus_out, 32'h0);
        rst_n = 1'b1;

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule